// File: doc/BRIEF.md
# I2C Configuration Register Bank with Nonvolatile Save and Restore

This block is an I2C target that sits in front of a bank of byte-wide configuration registers and a behavioural model of a nonvolatile store. The store holds four complete images of the bank. A host can write and read registers with pointer-based burst transfers. It can also set command bits in a dedicated register to copy the whole bank into one store image (save) or to copy an image back into the bank (restore).

The command does not start when the command byte arrives. It starts when the host ends the transfer with STOP. From then until the copy completes, the block acknowledges no address at all, so the host sees the target as absent or busy. A `busy_o` flag marks the same window. The same lockout applies after reset, while the block automatically restores the bank from the store. The host knows the block is ready when its address is acknowledged again.

The store model is loaded with a computed factory image under reset. The image selection input picks which of the four images a save or restore uses.

Top module: `i2c_nv_regbank`

## Requirements
- R1: After reset `busy_o` is 1 and the block runs an automatic restore from the image chosen by `nv_bank_sel_i`. When it completes, every register except the command register holds that image's value.
- R2: Under reset, store image b, register r holds the factory value (b mod 4)·64 + (r mod 64).
- R3: The 7-bit target address is 0x6A (write byte 0xD4) while bit 0 of register 0 is 0, and 0x68 (write byte 0xD0) while it is 1. Every other address is not acknowledged.
- R4: A write transfer is: address with R/W=0, one pointer byte, then data bytes. Each data byte is acknowledged, stored at the pointer, and the pointer then increments, wrapping from NUM_REGS-1 to 0.
- R5: A read returns bytes starting at the current pointer, with auto-increment. The pointer is normally set by a write of the pointer byte followed by a repeated START and the address with R/W=1. A master NACK ends the burst.
- R6: In register CMD_IDX (114), writing bit 3 = 1 requests a save and writing bit 0 = 1 requests a restore. When both bits are set, only the save is performed.
- R7: A requested operation starts only on the STOP that follows; `busy_o` stays 0 until then. `busy_o` is then 1 for exactly OP_CYCLES clock cycles.
- R8: While `busy_o` is 1, no address is acknowledged, including the block's own address.
- R9: On completion, bits 3 and 0 of the command register clear and its other bits are kept. The command register is never copied to or from the store.
- R10: A save writes the bank into the image chosen by `nv_bank_sel_i` at launch. A restore loads the bank from that image. The other images are left unchanged.
- R11: SCL and SDA pass through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high, and the block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| nv_bank_sel_i | input | $clog2(NUM_BANKS) | Store image used by save and restore |
| busy_o | output | 1 | Save, restore or power-up restore in progress |

## Verification
The bench probes the address while the power-up restore is still running and again during each save. A block that acknowledged there would let a host write into a bank that is about to be overwritten. The bench checks `busy_o` between the command byte and the STOP, which catches a design that launches too early, and it counts the busy window exactly. Bursts that wrap the pointer past the last register catch an off-by-one in the wrap. A command register that carries unrelated bits shows whether completion clears only the two command bits and whether that register leaks into a copy. A combined save-and-restore request, followed by restores from different images, shows both the priority rule and that each image is kept separate.

// File: rtl/i2c_nv_pkg.sv
package i2c_nv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } bus_state_e;

  localparam logic [6:0] ADDR_PRIMARY   = 7'h6A;
  localparam logic [6:0] ADDR_SECONDARY = 7'h68;

  // Factory content of store image 'bank', register 'idx'
  function automatic logic [7:0] nv_image(input int unsigned bank, input int unsigned idx);
    int unsigned v;
    v = (bank % 4) * 64 + (idx % 64);
    return v[7:0];
  endfunction

endpackage

// File: rtl/i2c_nv_sync.sv
module i2c_nv_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= din[g];
        sync_q <= meta_q;
      end
    end
    assign dout[g] = sync_q;
  end

endmodule

// File: rtl/i2c_nv_engine.sv
module i2c_nv_engine
  import i2c_nv_pkg::*;
#(
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [6:0]        my_addr,
  input  logic              busy_i,
  input  logic [7:0]        rd_data,
  output logic [REG_AW-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [7:0]        wr_data_o,
  output logic              stop_o,
  output logic              sda_oe_o
);

  bus_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [REG_AW-1:0] ptr_q, ptr_d;
  logic              first_q, first_d;
  logic              rw_q, rw_d;
  logic              ackon_q, ackon_d;
  logic              nack_q, nack_d;
  logic              oe_q, oe_d;
  logic              scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] byte_in;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_in   = {shreg_q[6:0], sda_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    rw_d    = rw_q;
    ackon_d = ackon_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    wr_en_o = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          shreg_d = byte_in;
          cnt_d   = cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            if (byte_in[7:1] == my_addr && !busy_i) begin
              state_d = ST_AACK;
              rw_d    = byte_in[0];
              ackon_d = 1'b0;
              if (!byte_in[0]) first_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: if (scl_fall) begin
          if (!ackon_q) begin
            ackon_d = 1'b1;
            oe_d    = 1'b1;
          end else begin
            ackon_d = 1'b0;
            oe_d    = 1'b0;
            cnt_d   = '0;
            if (state_q == ST_AACK && rw_q) begin
              state_d = ST_RBYTE;
              shreg_d = rd_data;
              oe_d    = ~rd_data[7];
            end else begin
              state_d = ST_WBYTE;
            end
          end
        end
        ST_WBYTE: if (scl_rise) begin
          shreg_d = byte_in;
          cnt_d   = cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            state_d = ST_WACK;
            ackon_d = 1'b0;
            if (first_q) begin
              ptr_d   = byte_in[REG_AW-1:0];
              first_d = 1'b0;
            end else begin
              wr_en_o = 1'b1;
              ptr_d   = ptr_q + 1'b1;
            end
          end
        end
        ST_RBYTE: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
              ptr_d   = ptr_q + 1'b1;
            end else begin
              shreg_d = {shreg_q[6:0], 1'b0};
              oe_d    = ~shreg_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_RBYTE;
              cnt_d   = '0;
              shreg_d = rd_data;
              oe_d    = ~rd_data[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      ackon_q <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      ackon_q <= ackon_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
      scl_q   <= scl_s;
      sda_q   <= sda_s;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = byte_in;
  assign stop_o    = stop_det;
  assign sda_oe_o  = oe_q;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> state_q != ST_AACK && state_q != ST_WACK); // R8
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !$stable(oe_q)) |-> !scl_s || !oe_q); // R11
  AST_SDA_ASSERT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R11
  AST_READ_BIT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RBYTE) |-> oe_q == ~shreg_q[7]); // R5

endmodule

// File: rtl/i2c_nv_seq.sv
module i2c_nv_seq #(
  parameter int OP_CYCLES = 1000,
  parameter int NB_W      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_i,
  input  logic            save_i,
  input  logic [NB_W-1:0] bank_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            save_o,
  output logic [NB_W-1:0] bank_o
);

  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYCLES - 1);

  logic             busy_q, busy_d;
  logic             auto_q, auto_d;
  logic             save_q, save_d;
  logic [NB_W-1:0]  bank_q, bank_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    auto_d = auto_q;
    save_d = save_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        auto_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (launch_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      save_d = save_i;
      bank_d = bank_i;
    end
  end

  // Power-up: busy with a restore pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      auto_q <= 1'b1;
      save_q <= 1'b0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      auto_q <= auto_d;
      save_q <= save_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign save_o = save_q;
  assign bank_o = auto_q ? bank_i : bank_q;

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R7
  AST_AUTO_IS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |-> busy_q && !save_q); // R1

endmodule

// File: rtl/i2c_nv_bank.sv
module i2c_nv_bank
  import i2c_nv_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int NUM_BANKS = 4,
  parameter int CMD_IDX   = 114
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] ptr,
  input  logic [7:0]                  wr_data,
  output logic [7:0]                  rd_data,
  input  logic                        done_i,
  input  logic                        save_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  output logic                        addr_sel_o,
  output logic                        cmd_save_o,
  output logic                        cmd_rest_o
);

  localparam int SAVE_BIT = 3;
  localparam int REST_BIT = 0;

  logic [7:0] regs_q  [NUM_REGS];
  logic [7:0] store_q [NUM_BANKS][NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (done_i) begin
      if (!save_i) begin
        for (int r = 0; r < NUM_REGS; r++)
          if (r != CMD_IDX) regs_q[r] <= store_q[bank_i][r];
      end
      regs_q[CMD_IDX][SAVE_BIT] <= 1'b0;
      regs_q[CMD_IDX][REST_BIT] <= 1'b0;
    end else if (wr_en) begin
      regs_q[ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < NUM_REGS; r++)
          store_q[b][r] <= nv_image(b, r);
    end else if (done_i && save_i) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (r != CMD_IDX) store_q[bank_i][r] <= regs_q[r];
    end
  end

  assign rd_data    = regs_q[ptr];
  assign addr_sel_o = regs_q[0][0];
  assign cmd_save_o = regs_q[CMD_IDX][SAVE_BIT];
  assign cmd_rest_o = regs_q[CMD_IDX][REST_BIT];

  AST_CMD_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !cmd_save_o && !cmd_rest_o); // R9
  AST_NO_WRITE_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> !wr_en); // R8

endmodule

// File: rtl/i2c_nv_regbank.sv
module i2c_nv_regbank
  import i2c_nv_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int NUM_BANKS = 4,
  parameter int CMD_IDX   = 114,
  parameter int OP_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe_o,
  input  logic [$clog2(NUM_BANKS)-1:0] nv_bank_sel_i,
  output logic                         busy_o
);

  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int NB_W   = $clog2(NUM_BANKS);

  logic [1:0]        sync_out;
  logic              scl_s, sda_s;
  logic [REG_AW-1:0] ptr;
  logic              wr_en, stop_p, busy, done, op_save;
  logic [7:0]        wr_data, rd_data;
  logic [NB_W-1:0]   op_bank;
  logic              addr_sel, cmd_save, cmd_rest, launch;
  logic [6:0]        my_addr;

  i2c_nv_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  assign my_addr = addr_sel ? ADDR_SECONDARY : ADDR_PRIMARY;

  i2c_nv_engine #(.REG_AW(REG_AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .my_addr(my_addr), .busy_i(busy), .rd_data(rd_data),
    .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .stop_o(stop_p), .sda_oe_o(sda_oe_o)
  );

  assign launch = stop_p && !busy && (cmd_save || cmd_rest);

  i2c_nv_seq #(.OP_CYCLES(OP_CYCLES), .NB_W(NB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .save_i(cmd_save),
    .bank_i(nv_bank_sel_i), .busy_o(busy), .done_o(done),
    .save_o(op_save), .bank_o(op_bank)
  );

  i2c_nv_bank #(.NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .CMD_IDX(CMD_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .rd_data(rd_data), .done_i(done), .save_i(op_save), .bank_i(op_bank),
    .addr_sel_o(addr_sel), .cmd_save_o(cmd_save), .cmd_rest_o(cmd_rest)
  );

  assign busy_o = busy;

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_p)); // R7
  AST_SAVE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cmd_save) |=> op_save); // R6

endmodule

// File: tb/i2c_nv_regbank_tb_top.sv
`timescale 1ns/1ps
module i2c_nv_regbank_tb_top;

  localparam int NREG = 128;
  localparam int CMD  = 114;
  localparam int OPC  = 300;
  localparam int H    = 40;
  localparam int Q    = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic [1:0] bank_sel;
  logic       sda_oe, busy;
  wire        sda_line = m_sda & ~sda_oe;

  int vectors = 0;
  int fails   = 0;
  logic [6:0] dev;
  int exp_regs [NREG];
  int exp_store [4][NREG];
  int wbuf [NREG];

  always #4 clk = ~clk;

  i2c_nv_regbank #(.NUM_REGS(NREG), .NUM_BANKS(4), .CMD_IDX(CMD), .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .nv_bank_sel_i(bank_sel), .busy_o(busy)
  );

  function automatic int img(int b, int r);
    return ((b % 4) * 64 + (r % 64)) & 255;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; #H; m_scl = 1'b1; #H; m_sda = 1'b0; #H; m_scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; #H; m_scl = 1'b1; #H; m_sda = 1'b1; #H;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #H; m_scl = 1'b1; #H; m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #H; m_scl = 1'b1; #(H/2); ack = ~sda_line; #(H/2); m_scl = 1'b0; #Q;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #H; m_scl = 1'b1; #(H/2); b[i] = sda_line; #(H/2); m_scl = 1'b0; #Q;
    end
    m_sda = last; #H; m_scl = 1'b1; #H; m_scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  // address-only probe, returns ack
  task automatic probe(input logic [6:0] a, output logic ack);
    i2c_start(); wr_byte({a, 1'b0}, ack); i2c_stop();
  endtask

  // write burst from wbuf, no STOP
  task automatic wr_burst(input int ptr, input int n);
    logic ack;
    i2c_start();
    wr_byte({dev, 1'b0}, ack); chk("R4 address ack", ack, 1);
    wr_byte(8'(ptr), ack);     chk("R4 pointer ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(8'(wbuf[k]), ack); chk("R4 data ack", ack, 1);
      exp_regs[(ptr + k) % NREG] = wbuf[k];
    end
  endtask

  task automatic rd_burst(input int ptr, input int n);
    logic ack;
    logic [7:0] b;
    i2c_start();
    wr_byte({dev, 1'b0}, ack); chk("R5 address ack", ack, 1);
    wr_byte(8'(ptr), ack);     chk("R5 pointer ack", ack, 1);
    i2c_start();
    wr_byte({dev, 1'b1}, ack); chk("R11 repeated START ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k == n - 1, b);
      chk($sformatf("R5 R10 read reg %0d", (ptr + k) % NREG), b, exp_regs[(ptr + k) % NREG]);
    end
    i2c_stop();
  endtask

  task automatic measure(output int len);
    int t;
    t = 0;
    while (!busy && t < 60) begin @(negedge clk); t++; end
    len = 0;
    while (busy && len < 5000) begin len++; @(negedge clk); end
  endtask

  // issue command byte, STOP, check window and lockout, update model
  task automatic run_cmd(input int val, input int bank);
    int len;
    logic ack;
    bank_sel = 2'(bank);
    wbuf[0] = val;
    wr_burst(CMD, 1);
    #H;
    chk("R7 busy low before STOP", busy, 0);
    fork
      begin i2c_stop(); probe(dev, ack); chk("R8 no ack during operation", ack, 0); end
      begin measure(len); end
    join
    chk("R7 busy length", len, OPC);
    if (val & 8) begin
      for (int r = 0; r < NREG; r++) if (r != CMD) exp_store[bank][r] = exp_regs[r];
    end else if (val & 1) begin
      for (int r = 0; r < NREG; r++) if (r != CMD) exp_regs[r] = exp_store[bank][r];
    end
    exp_regs[CMD] = exp_regs[CMD] & ~9;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int len;
    logic ack;
    m_scl = 1'b1; m_sda = 1'b1; bank_sel = 2'd2; rst_n = 1'b0;
    dev = 7'h6A;
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < NREG; r++) exp_store[b][r] = img(b, r);
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R11 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    chk("R1 busy after reset", busy, 1);
    fork
      begin measure(len); end
      begin probe(7'h6A, ack); chk("R8 no ack during power-up restore", ack, 0); end
    join
    chk("R1 R7 power-up busy length", len, OPC);
    for (int r = 0; r < NREG; r++) exp_regs[r] = (r == CMD) ? 0 : img(2, r);
    rd_burst(0, NREG);                       // R1 R2

    for (int a = 0; a < 128; a++) begin      // R3 address sweep
      probe(7'(a), ack);
      chk($sformatf("R3 address %0h", a), ack, (a == 'h6A) ? 1 : 0);
    end

    for (int k = 0; k < 6; k++) wbuf[k] = 16 + 2 * k;   // R4 wrap
    wr_burst(124, 6); i2c_stop();
    rd_burst(122, 10);
    for (int k = 0; k < 112; k++) wbuf[k] = ((k + 2) * 7 + 3) & 255;
    wr_burst(2, 112); i2c_stop();

    wbuf[0] = 'h48;                          // R9 unrelated bits kept
    run_cmd('h48, 1);
    rd_burst(CMD, 1);
    for (int k = 0; k < 112; k++) wbuf[k] = ~(((k + 2) * 7 + 3)) & 255;
    wr_burst(2, 112); i2c_stop();
    run_cmd('h01, 1);                        // R10 restore from image 1
    rd_burst(0, NREG);
    run_cmd('h01, 0);                        // R10 image 0 untouched
    rd_burst(0, 16);
    rd_burst(110, 18);
    run_cmd('h09, 3);                        // R6 save wins
    rd_burst(0, 16);
    for (int k = 0; k < 8; k++) wbuf[k] = 'hA5 ^ k;
    wr_burst(2, 8); i2c_stop();
    run_cmd('h01, 3);
    rd_burst(0, NREG);

    wbuf[0] = 1;                             // R3 secondary address
    wr_burst(0, 1); i2c_stop();
    probe(7'h6A, ack); chk("R3 primary refused after select", ack, 0);
    probe(7'h68, ack); chk("R3 secondary accepted", ack, 1);
    dev = 7'h68;
    rd_burst(0, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule